// File: doc/BRIEF.md
# Strided Stream Queue Channel

This block is a single stream channel that sits next to the data cache and moves array-like data between the CPU and memory without going through the cache. Software arms it with a start address, a stride counted in elements, an element size and an optional element count. It also selects a direction. In the read direction the channel fetches elements ahead of demand into a small internal buffer, and the CPU pops them one at a time in element order. In the write direction the CPU pushes elements into the buffer, and the channel drains them to memory in groups.

On the memory side, accesses go out as groups of back-to-back beats, one element per beat. A group never crosses a page boundary and never exceeds a fixed length, so each group can be served from one open DRAM page. A small sequencer decides when a group may start. A read group starts once enough buffer space is free. A write group starts once enough data has gathered, or once the last counted element has been pushed. The CPU side stalls by holding its ready signal low.

Top module: `ssq_stream_channel`

## Requirements
- R1: A one-cycle `cfg_start` loads direction, start address, stride, size and count, empties the buffer and clears progress and `done`. The first memory beat that follows targets the start address.
- R2: Element i sits at start + i × stride × bytes, where `cfg_size` 0 is 1 byte, 1 is 4 bytes and 2 is 8 bytes. Memory beats visit elements in increasing i, and `mem_we` equals the configured direction.
- R3: In read direction, `pop_data` of the i-th pop equals the low 1, 4 or 8 bytes of the memory read data for element i, zero-extended.
- R4: `pop_ready` is low while the buffer is empty, and `push_ready` is low while it is full. A stalled request is not taken.
- R5: A read group starts only when at least DEPTH/2 buffer entries are free. Fetching stops when the buffer is full.
- R6: A write group starts only when the buffer holds at least DEPTH/2 elements, or when every counted element has been pushed. `mem_wdata` is the pushed element masked to its size.
- R7: A group is the run of beats from one `mem_first` beat up to the next one. All beats of a group lie in one page of PAGE_BYTES, so crossing a page always starts a new group.
- R8: No group has more than MAX_BURST beats.
- R9: A count of 0 means the stream has no end. With count N > 0, no more than N elements reach memory, pushes beyond N are refused, and `done` rises once the N-th element has been popped (read) or written to memory (write).
- R10: After reset, `pop_ready`, `push_ready`, `mem_req` and `done` are low.
- R11: While `mem_req` is high and `mem_ready` is low, the request stays up with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | One-cycle pulse that arms the channel |
| cfg_write | input | 1 | 1 = write direction, 0 = read direction |
| cfg_base | input | AW | Byte address of element 0 |
| cfg_stride | input | SW | Distance between elements, in elements |
| cfg_size | input | 2 | Element size code: 0 byte, 1 word, 2 double word |
| cfg_count | input | CW | Element count, 0 for unbounded |
| pop_req | input | 1 | CPU takes the head element |
| pop_ready | output | 1 | Head element valid on pop_data |
| pop_data | output | DW | Head element, zero-extended |
| push_valid | input | 1 | CPU offers an element |
| push_ready | output | 1 | Channel accepts the offered element |
| push_data | input | DW | Element being pushed |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | Beat is a write |
| mem_first | output | 1 | Beat opens a new group |
| mem_addr | output | AW | Byte address of the beat |
| mem_wdata | output | DW | Write data of the beat |
| mem_ready | input | 1 | Memory takes the beat (read data valid in the same cycle) |
| mem_rdata | input | DW | Read data of the beat |
| done | output | 1 | Counted stream complete |

## Verification
The bench builds the channel with an 8-entry buffer, 64-byte pages and groups capped at 4 beats. With these values, page crossings, group caps and buffer-full stalls all occur within a dozen elements. Every beat is checked against the address formula and against the page and length rules for groups, for byte, word and double-word streams, with and without memory stalls. The half-buffer thresholds are checked by counting beats at exact buffer fill levels.

// File: rtl/ssq_pkg.sv
package ssq_pkg;

  typedef enum logic [1:0] {
    ESZ_BYTE  = 2'd0,
    ESZ_WORD  = 2'd1,
    ESZ_DWORD = 2'd2
  } esize_e;

  typedef enum logic [1:0] {
    CH_IDLE  = 2'd0,
    CH_HOLD  = 2'd1,
    CH_BURST = 2'd2
  } ch_state_e;

  // log2 of the element size in bytes
  function automatic logic [1:0] size_shift(input logic [1:0] code);
    case (esize_e'(code))
      ESZ_WORD:  size_shift = 2'd2;
      ESZ_DWORD: size_shift = 2'd3;
      default:   size_shift = 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ssq_fifo.sv
module ssq_fifo #(
  parameter int DW    = 64,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_en,
  output logic [DW-1:0]            rd_data,
  output logic [$clog2(DEPTH):0]   occ,
  output logic                     full,
  output logic                     empty
);
  localparam int PW = $clog2(DEPTH);

  logic [DW-1:0] ram [DEPTH];
  logic [PW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (wr_en) ram[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      occ <= '0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: ;
      endcase
    end
  end

  assign rd_data = ram[rp];
  assign full    = (occ == ($clog2(DEPTH)+1)'(DEPTH));
  assign empty   = (occ == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) wr_en |-> !full); // R4
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) rd_en |-> !empty); // R4

endmodule

// File: rtl/ssq_addr_gen.sv
module ssq_addr_gen #(
  parameter int AW        = 32,
  parameter int SW        = 16,
  parameter int PAGE_BITS = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic [SW-1:0] stride,
  input  logic [1:0]    size,
  input  logic          advance,
  output logic [AW-1:0] addr,
  output logic          cross_next
);
  import ssq_pkg::*;

  logic [AW-1:0] step_q;
  logic [AW-1:0] nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      step_q <= '0;
    end else if (load) begin
      addr   <= base;
      step_q <= AW'(stride) << size_shift(size);
    end else if (advance) begin
      addr   <= nxt;
    end
  end

  assign nxt        = addr + step_q;
  assign cross_next = (nxt[AW-1:PAGE_BITS] != addr[AW-1:PAGE_BITS]);

endmodule

// File: rtl/ssq_stream_channel.sv
module ssq_stream_channel #(
  parameter int AW         = 32,
  parameter int DW         = 64,
  parameter int SW         = 16,
  parameter int CW         = 16,
  parameter int DEPTH      = 16,
  parameter int PAGE_BYTES = 2048,
  parameter int MAX_BURST  = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_start,
  input  logic          cfg_write,
  input  logic [AW-1:0] cfg_base,
  input  logic [SW-1:0] cfg_stride,
  input  logic [1:0]    cfg_size,
  input  logic [CW-1:0] cfg_count,
  input  logic          pop_req,
  output logic          pop_ready,
  output logic [DW-1:0] pop_data,
  input  logic          push_valid,
  output logic          push_ready,
  input  logic [DW-1:0] push_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_first,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          done
);
  import ssq_pkg::*;

  localparam int OCC_W     = $clog2(DEPTH) + 1;
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);
  localparam int BC_W      = $clog2(MAX_BURST) + 1;
  localparam int HALF      = DEPTH / 2;

  ch_state_e     state;
  logic          wr_mode;
  logic [1:0]    size_q;
  logic [CW-1:0] count_q, cpu_cnt, iss_cnt;
  logic [BC_W-1:0] bcnt;
  logic          first_q, done_q;

  logic             f_wr, f_rd, f_full, f_empty;
  logic [DW-1:0]    f_wdata, f_rdata;
  logic [OCC_W-1:0] f_occ, f_free;
  logic             ag_cross;

  logic beat, cpu_hs, cnt_lim, rd_left, all_pushed;
  logic start_rd, start_wr, buf_stop, cnt_end, stop;

  function automatic logic [DW-1:0] fit(input logic [1:0] s, input logic [DW-1:0] d);
    case (s)
      2'd0:    fit = DW'(d[7:0]);
      2'd1:    fit = DW'(d[31:0]);
      default: fit = d;
    endcase
  endfunction

  // CPU-side handshakes
  assign pop_ready  = (state != CH_IDLE) && !wr_mode && !f_empty;
  assign push_ready = (state != CH_IDLE) && wr_mode && !f_full &&
                      (!cnt_lim || cpu_cnt != count_q);
  assign cpu_hs     = wr_mode ? (push_valid && push_ready) : (pop_req && pop_ready);

  // Memory side
  assign mem_req   = (state == CH_BURST);
  assign mem_first = first_q;
  assign mem_we    = wr_mode;
  assign mem_wdata = f_rdata;
  assign beat      = mem_req && mem_ready;
  assign pop_data  = f_rdata;
  assign done      = done_q;

  // Buffer routing depends on direction
  assign f_wr    = wr_mode ? (push_valid && push_ready) : beat;
  assign f_rd    = wr_mode ? beat : (pop_req && pop_ready);
  assign f_wdata = fit(size_q, wr_mode ? push_data : mem_rdata);
  assign f_free  = OCC_W'(DEPTH) - f_occ;

  // Group start and stop decisions
  assign cnt_lim    = (count_q != '0);
  assign rd_left    = !cnt_lim || (iss_cnt != count_q);
  assign all_pushed = cnt_lim && (cpu_cnt == count_q);
  assign start_rd   = !wr_mode && rd_left && (f_free >= OCC_W'(HALF));
  assign start_wr   = wr_mode && ((f_occ >= OCC_W'(HALF)) || (all_pushed && !f_empty));
  assign buf_stop   = wr_mode ? (f_occ == OCC_W'(1)) : (f_occ >= OCC_W'(DEPTH - 1));
  assign cnt_end    = cnt_lim && (iss_cnt + CW'(1) == count_q);
  assign stop       = (bcnt == BC_W'(MAX_BURST - 1)) || ag_cross || buf_stop || cnt_end;

  ssq_fifo #(.DW(DW), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .clr(cfg_start),
    .wr_en(f_wr), .wr_data(f_wdata),
    .rd_en(f_rd), .rd_data(f_rdata),
    .occ(f_occ), .full(f_full), .empty(f_empty)
  );

  ssq_addr_gen #(.AW(AW), .SW(SW), .PAGE_BITS(PAGE_BITS)) u_agen (
    .clk(clk), .rst(rst), .load(cfg_start),
    .base(cfg_base), .stride(cfg_stride), .size(cfg_size),
    .advance(beat && !cfg_start),
    .addr(mem_addr), .cross_next(ag_cross)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= CH_IDLE;
      wr_mode <= 1'b0;
      size_q  <= '0;
      count_q <= '0;
      cpu_cnt <= '0;
      iss_cnt <= '0;
      bcnt    <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (cfg_start) begin
      state   <= CH_HOLD;
      wr_mode <= cfg_write;
      size_q  <= cfg_size;
      count_q <= cfg_count;
      cpu_cnt <= '0;
      iss_cnt <= '0;
      bcnt    <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (cpu_hs) cpu_cnt <= cpu_cnt + CW'(1);
      done_q <= (state != CH_IDLE) && cnt_lim &&
                (wr_mode ? (iss_cnt == count_q) : (cpu_cnt == count_q));
      case (state)
        CH_HOLD: begin
          if (start_rd || start_wr) begin
            state   <= CH_BURST;
            first_q <= 1'b1;
            bcnt    <= '0;
          end
        end
        CH_BURST: begin
          if (beat) begin
            iss_cnt <= iss_cnt + CW'(1);
            bcnt    <= bcnt + BC_W'(1);
            first_q <= 1'b0;
            if (stop) state <= CH_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  // Group tracking for the assertions below
  logic [AW-PAGE_BITS-1:0] grp_page_q;
  logic [BC_W-1:0]         grp_len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_page_q <= '0;
      grp_len_q  <= '0;
    end else if (beat) begin
      grp_page_q <= mem_addr[AW-1:PAGE_BITS];
      grp_len_q  <= mem_first ? BC_W'(1) : grp_len_q + BC_W'(1);
    end
  end

  AST_GROUP_PAGE: assert property (@(posedge clk) disable iff (rst) (beat && !mem_first) |-> (mem_addr[AW-1:PAGE_BITS] == grp_page_q)); // R7
  AST_GROUP_CAP: assert property (@(posedge clk) disable iff (rst) (beat && !mem_first) |-> (grp_len_q < BC_W'(MAX_BURST))); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst) (mem_req && !mem_ready && !cfg_start) |=> (mem_req && $stable(mem_addr))); // R11
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) done |-> (!push_ready && !pop_ready)); // R9

endmodule

// File: tb/ssq_stream_channel_tb.sv
module ssq_stream_channel_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32, DW = 64, SW = 8, CW = 8;
  localparam int DEPTH = 8, PAGE_BYTES = 64, MAX_BURST = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_start = 0, cfg_write = 0;
  logic [AW-1:0] cfg_base = '0;
  logic [SW-1:0] cfg_stride = '0;
  logic [1:0]    cfg_size = '0;
  logic [CW-1:0] cfg_count = '0;
  logic pop_req = 0, pop_ready;
  logic [DW-1:0] pop_data;
  logic push_valid = 0, push_ready;
  logic [DW-1:0] push_data = '0;
  logic mem_req, mem_we, mem_first, mem_ready = 0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic done;

  int checks = 0, errors = 0, cyc = 0;
  bit ready_en = 0, stall_pat = 0;
  logic [AW-1:0] m_base;
  logic [SW-1:0] m_stride;
  logic [1:0]    m_size;
  logic [CW-1:0] m_count;
  bit  m_write;
  int  beat_idx = 0, beats = 0, grp_len = 0;
  logic [AW-1:0] grp_page, pend_addr;
  bit  pend_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssq_stream_channel #(.AW(AW), .DW(DW), .SW(SW), .CW(CW), .DEPTH(DEPTH),
                       .PAGE_BYTES(PAGE_BYTES), .MAX_BURST(MAX_BURST)) u_dut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_write(cfg_write),
    .cfg_base(cfg_base), .cfg_stride(cfg_stride), .cfg_size(cfg_size), .cfg_count(cfg_count),
    .pop_req(pop_req), .pop_ready(pop_ready), .pop_data(pop_data),
    .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_first(mem_first), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .done(done)
  );

  assign mem_rdata = {mem_addr, mem_addr ^ 32'h5A5A_5A5A};

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) mem_ready <= ready_en && (!stall_pat || (cyc % 3 != 0));

  function automatic logic [DW-1:0] emask(input logic [1:0] s, input logic [DW-1:0] d);
    case (s)
      2'd0:    emask = {56'd0, d[7:0]};
      2'd1:    emask = {32'd0, d[31:0]};
      default: emask = d;
    endcase
  endfunction

  function automatic logic [AW-1:0] eaddr(input int i);
    int nb;
    nb = (m_size == 2'd0) ? 1 : (m_size == 2'd1) ? 4 : 8;
    eaddr = m_base + AW'(i) * AW'(m_stride) * AW'(nb);
  endfunction

  function automatic logic [DW-1:0] wdat(input int i);
    wdat = {32'hC0DE_0000 + 32'(i), 32'h1234_5600 + 32'(i * 3)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  // Beat monitor: samples just after the falling edge
  always @(negedge clk) begin
    #1;
    if (!rst && mem_req) begin
      if (pend_valid) chk(mem_addr == pend_addr, "R11 held address", 64'(mem_addr), 64'(pend_addr));
      if (mem_ready) begin
        pend_valid = 0;
        if (beat_idx == 0) chk(mem_addr == eaddr(0), "R1 first beat at start", 64'(mem_addr), 64'(eaddr(0)));
        else chk(mem_addr == eaddr(beat_idx), "R2 beat address", 64'(mem_addr), 64'(eaddr(beat_idx)));
        chk(mem_we == m_write, "R2 direction", 64'(mem_we), 64'(m_write));
        if (mem_first) begin
          grp_page = mem_addr >> $clog2(PAGE_BYTES);
          grp_len = 1;
        end else begin
          grp_len++;
          chk((mem_addr >> $clog2(PAGE_BYTES)) == grp_page, "R7 group page",
              64'(mem_addr >> $clog2(PAGE_BYTES)), 64'(grp_page));
          chk(grp_len <= MAX_BURST, "R8 group length", 64'(grp_len), 64'(MAX_BURST));
        end
        if (m_write) chk(mem_wdata == emask(m_size, wdat(beat_idx)), "R6 write data",
                         mem_wdata, emask(m_size, wdat(beat_idx)));
        if (m_count != 0) chk(beat_idx < int'(m_count), "R9 beat beyond count", 64'(beat_idx), 64'(m_count));
        beat_idx++;
        beats++;
      end else begin
        pend_valid = 1;
        pend_addr = mem_addr;
      end
    end else begin
      pend_valid = 0;
    end
  end

  task automatic configure(input bit w, input logic [AW-1:0] b, input logic [SW-1:0] s,
                           input logic [1:0] sz, input logic [CW-1:0] c);
    @(negedge clk);
    cfg_write = w; cfg_base = b; cfg_stride = s; cfg_size = sz; cfg_count = c;
    cfg_start = 1;
    m_write = w; m_base = b; m_stride = s; m_size = sz; m_count = c;
    beat_idx = 0; beats = 0; pend_valid = 0;
    @(negedge clk);
    cfg_start = 0;
  endtask

  task automatic pop_one(input int i);
    int t = 0;
    logic [DW-1:0] e;
    @(negedge clk); #1;
    while (!pop_ready && t < 300) begin @(negedge clk); #1; t++; end
    e = emask(m_size, {eaddr(i), eaddr(i) ^ 32'h5A5A_5A5A});
    chk(pop_data == e, "R3 pop data", pop_data, e);
    pop_req = 1;
    @(negedge clk);
    pop_req = 0;
  endtask

  task automatic push_one(input int i);
    int t = 0;
    @(negedge clk);
    push_valid = 1; push_data = wdat(i);
    #1;
    while (!push_ready && t < 300) begin @(negedge clk); #1; t++; end
    @(negedge clk);
    push_valid = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic read_stream(input logic [AW-1:0] b, input logic [SW-1:0] s,
                             input logic [1:0] sz, input int n);
    configure(0, b, s, sz, CW'(n));
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) chk(done == 0, "R9 done early", 64'(done), 64'(0));
      pop_one(i);
    end
    wait_cyc(3);
    chk(done == 1, "R9 done after last pop", 64'(done), 64'(1));
    chk(beats == n, "R9 beat total", 64'(beats), 64'(n));
    chk(pop_ready == 0, "R4 empty after stream", 64'(pop_ready), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(pop_ready == 0, "R10 pop_ready", 64'(pop_ready), 64'(0));
    chk(push_ready == 0, "R10 push_ready", 64'(push_ready), 64'(0));
    chk(mem_req == 0, "R10 mem_req", 64'(mem_req), 64'(0));
    chk(done == 0, "R10 done", 64'(done), 64'(0));
    @(negedge clk);
    rst = 0;

    // Read streams across sizes, strides and page boundaries
    ready_en = 1; stall_pat = 0;
    read_stream(32'h30, 8'd1, 2'd1, 20);
    stall_pat = 1;
    read_stream(32'h12B, 8'd3, 2'd0, 12);
    read_stream(32'h1F0, 8'd2, 2'd2, 10);

    // Read-ahead thresholds on an unbounded stream
    stall_pat = 0;
    configure(0, 32'h0, 8'd1, 2'd1, 8'd0);
    #1;
    chk(pop_ready == 0, "R4 pop stalls while empty", 64'(pop_ready), 64'(0));
    wait_cyc(30);
    chk(beats == 8, "R5 fill stops at full", 64'(beats), 64'(8));
    for (int i = 0; i < 3; i++) pop_one(i);
    wait_cyc(20);
    chk(beats == 8, "R5 no fetch below half free", 64'(beats), 64'(8));
    pop_one(3);
    wait_cyc(20);
    chk(beats == 12, "R5 fetch at half free", 64'(beats), 64'(12));

    // Write gathering with a count
    configure(1, 32'h38, 8'd2, 2'd1, 8'd11);
    for (int i = 0; i < 3; i++) push_one(i);
    wait_cyc(10);
    chk(beats == 0, "R6 gather below half", 64'(beats), 64'(0));
    for (int i = 3; i < 11; i++) push_one(i);
    #1;
    chk(push_ready == 0, "R9 push refused after count", 64'(push_ready), 64'(0));
    begin
      int t = 0;
      while (!done && t < 300) begin @(negedge clk); #1; t++; end
    end
    chk(done == 1, "R9 done after last write", 64'(done), 64'(1));
    chk(beats == 11, "R9 write beat total", 64'(beats), 64'(11));

    // Write buffer full with memory stalled
    ready_en = 0;
    configure(1, 32'h200, 8'd1, 2'd0, 8'd0);
    for (int i = 0; i < 8; i++) push_one(i);
    @(negedge clk);
    push_valid = 1; push_data = wdat(8);
    wait_cyc(5);
    chk(push_ready == 0, "R4 push stalls while full", 64'(push_ready), 64'(0));
    chk(beats == 0, "R11 no beat without ready", 64'(beats), 64'(0));
    @(negedge clk);
    push_valid = 0;
    ready_en = 1;
    wait_cyc(30);
    chk(beats == 8, "R6 drain of gathered data", 64'(beats), 64'(8));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule